// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Lead-In and Repeat Count

This block is a six-channel pulse-width modulator behind a simple synchronous register bus. Each channel drives one output bit. A channel has two 32-bit registers. The control register holds an enable flag, a lead-in delay and a repeat count. The timing register holds the lengths of the high and low phases. All lengths are counted in cycles of the block clock.

When a channel is switched on, its output stays low for the lead-in delay. It then produces periods, each made of a high phase followed by a low phase. The channel stops after the programmed number of periods, or runs forever when that number is zero. Software may rewrite the high and low lengths while a channel runs. The period already in progress always finishes with the lengths it started with. Switching a channel off cuts its output at once.

The bus takes a byte address, a write strobe and write data. Read data follows the address combinationally, in the same cycle.

Top module: `pwm_leadin_array`

## Requirements
- R1: Channel c (0 to 5) has its control register at byte address 4*c and its timing register at byte address 0x20 + 4*c. Each channel's output is bit c of `pwm_out`. A write to one channel's register changes no other channel.
- R2: Control register fields: bit 31 is the enable, bits 30:16 are the lead-in length, bits 15:0 are the repeat count. Timing register fields: bits 31:16 are the high length, bits 15:0 are the low length. A read returns the last written word, except that the enable bit reads 0 after the channel stops by itself.
- R3: Consider the clock edge that writes the enable from 0 to 1 with lead-in L. The output is low for the L cycles after that edge, and the high phase starts in the cycle after those. With L = 0 the high phase starts in the first cycle after the write.
- R4: Each period is H high cycles followed by Lo low cycles. With H = 0 the output stays low. With Lo = 0 and H > 0 the output stays high. With H = Lo = 0 a period lasts one low cycle.
- R5: With a nonzero repeat count N, the channel outputs exactly N periods, then holds its output low and clears its own enable bit. With N = 0 it repeats without end.
- R6: A control write with bit 31 = 0 makes the output low from the first cycle after that write and abandons the current period. Enabling the channel again restarts it from its lead-in.
- R7: A timing write while the channel runs does not change the period in progress. The new high and low lengths apply from the next period boundary.
- R8: These addresses are unmapped: 0x18, 0x1C, 0x38, 0x3C, any address of 0x40 or above, and any address with bits 1:0 nonzero. Unmapped addresses read as 0, and writes to them change no register and no output.
- R9: A synchronous active-high reset clears every register and drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all lengths count its cycles |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 6 | One modulated output per channel |

## Verification
The main sweep steps high and low lengths through every combination of 0 to 3 cycles. It uses lead-ins of 0 and 2, with endless and two-period repeat counts, and rotates over all six channels. The zero-length corners show the constant-low, constant-high and one-cycle-period cases apart from normal cycling. The two lead-ins show whether the start delay is counted exactly. The finite repeat count shows whether the channel stops on the right boundary and clears its own enable. Separate patterns cover three cases: a disable in the middle of a high phase followed by a restart, a timing rewrite part-way into a period, and accesses to every class of unmapped address.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  // Phase of one channel's sequencer
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOW  = 2'd3
  } phase_e;

  localparam int DEF_NUM_CH   = 6;
  localparam int DEF_ADDR_W   = 8;
  localparam int DEF_PH_W     = 16;
  localparam int DEF_RPT_W    = 16;
  localparam int DEF_TIM_BASE = 'h20;
endpackage

// File: rtl/pwm_bus_dec.sv
module pwm_bus_dec #(
  parameter int NUM_CH   = 6,
  parameter int ADDR_W   = 8,
  parameter int TIM_BASE = 'h20
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] ctl_sel,
  output logic [NUM_CH-1:0] tim_sel,
  output logic              hit
);
  // One compare per channel and register; any other address selects nothing
  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    localparam int CTL_ADDR = 4 * i;
    localparam int TIM_ADDR = TIM_BASE + 4 * i;
    assign ctl_sel[i] = (addr == ADDR_W'(CTL_ADDR));
    assign tim_sel[i] = (addr == ADDR_W'(TIM_ADDR));
  end

  assign hit = |{ctl_sel, tim_sel};
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int PH_W   = 16,
  parameter int RPT_W  = 16,
  parameter int DATA_W = 2 * PH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              tim_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] tim_q,
  output logic              pwm_o
);
  localparam int LEAD_W = DATA_W - 1 - RPT_W;
  localparam int CNT_W  = (LEAD_W > PH_W) ? LEAD_W : PH_W;

  // Arithmetic kept in functions so the rules stay readable
  function automatic logic [CNT_W-1:0] len_to_remain(input logic [PH_W-1:0] len);
    return (len == '0) ? '0 : CNT_W'(len - PH_W'(1));
  endfunction

  function automatic logic rpt_reached(input logic [RPT_W-1:0] done,
                                       input logic [RPT_W-1:0] lim);
    return (lim != '0) && (({1'b0, done} + (RPT_W+1)'(1)) >= {1'b0, lim});
  endfunction

  // Registers seen by software
  logic              en_q;
  logic [LEAD_W-1:0] lead_q;
  logic [RPT_W-1:0]  rpt_q;
  logic [PH_W-1:0]   hi_q, lo_q;
  // Running state
  logic [PH_W-1:0]   act_hi, act_lo;
  phase_e            phase_q;
  logic [CNT_W-1:0]  remain_q;
  logic [RPT_W-1:0]  done_q;

  // Decoded write fields
  logic              wr_en;
  logic [LEAD_W-1:0] wr_lead;
  logic [RPT_W-1:0]  wr_rpt;
  assign wr_en   = wdata[DATA_W-1];
  assign wr_lead = wdata[RPT_W +: LEAD_W];
  assign wr_rpt  = wdata[RPT_W-1:0];

  // Named events
  logic turn_on, turn_off, phase_done, lead_done, period_end, last_period, self_stop;
  assign turn_off    = ctl_we && !wr_en;
  assign phase_done  = (phase_q != PH_IDLE) && (remain_q == '0);
  assign lead_done   = phase_done && (phase_q == PH_LEAD);
  assign period_end  = phase_done &&
                       ((phase_q == PH_LOW) || (phase_q == PH_HIGH && act_lo == '0));
  assign last_period = rpt_reached(done_q, rpt_q);
  assign self_stop   = period_end && last_period;
  assign turn_on     = ctl_we && wr_en && (!en_q || self_stop);

  // First phase of a new period, taken from the software copy
  phase_e           st_phase;
  logic [CNT_W-1:0] st_remain;
  always_comb begin
    if (hi_q != '0) begin
      st_phase  = PH_HIGH;
      st_remain = len_to_remain(hi_q);
    end else begin
      st_phase  = PH_LOW;
      st_remain = len_to_remain(lo_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      lead_q   <= '0;
      rpt_q    <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
      act_hi   <= '0;
      act_lo   <= '0;
      phase_q  <= PH_IDLE;
      remain_q <= '0;
      done_q   <= '0;
    end else begin
      if (tim_we) begin
        hi_q <= wdata[PH_W +: PH_W];
        lo_q <= wdata[PH_W-1:0];
      end
      if (ctl_we) begin
        en_q   <= wr_en;
        lead_q <= wr_lead;
        rpt_q  <= wr_rpt;
      end else if (self_stop) begin
        en_q <= 1'b0;
      end

      if (turn_off) begin
        phase_q <= PH_IDLE;
      end else if (turn_on) begin
        done_q <= '0;
        if (wr_lead == '0) begin
          phase_q  <= st_phase;
          remain_q <= st_remain;
          act_hi   <= hi_q;
          act_lo   <= lo_q;
        end else begin
          phase_q  <= PH_LEAD;
          remain_q <= CNT_W'(wr_lead - LEAD_W'(1));
        end
      end else if (phase_q != PH_IDLE && remain_q != '0) begin
        remain_q <= remain_q - CNT_W'(1);
      end else if (lead_done) begin
        phase_q  <= st_phase;
        remain_q <= st_remain;
        act_hi   <= hi_q;
        act_lo   <= lo_q;
      end else if (phase_q == PH_HIGH && act_lo != '0) begin
        phase_q  <= PH_LOW;
        remain_q <= len_to_remain(act_lo);
      end else if (period_end) begin
        done_q <= done_q + RPT_W'(1);
        if (last_period) begin
          phase_q <= PH_IDLE;
        end else begin
          phase_q  <= st_phase;
          remain_q <= st_remain;
          act_hi   <= hi_q;
          act_lo   <= lo_q;
        end
      end
    end
  end

  assign pwm_o = (phase_q == PH_HIGH);
  assign ctl_q = {en_q, lead_q, rpt_q};
  assign tim_q = {hi_q, lo_q};

  // Assertions
  AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !pwm_o); // R6
  AST_DISABLE_CUTS: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && !wr_en) |=> !pwm_o); // R6
  AST_SELF_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (self_stop && !ctl_we) |=> (!en_q && !pwm_o)); // R5
  AST_MID_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((phase_q == PH_HIGH || phase_q == PH_LOW) && !period_end)
      |=> ($stable(act_hi) && $stable(act_lo))); // R7
  AST_LOW_ZERO_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_HIGH && act_lo == '0 && period_end && !last_period &&
     hi_q != '0 && !ctl_we && !tim_we) |=> pwm_o); // R4
  AST_LEAD_STARTS_LOW: assert property (@(posedge clk) disable iff (rst)
    (turn_on && !turn_off && wr_lead != '0) |=> !pwm_o); // R3
endmodule

// File: rtl/pwm_leadin_array.sv
module pwm_leadin_array
  import pwm_pkg::*;
#(
  parameter int NUM_CH   = DEF_NUM_CH,
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int PH_W     = DEF_PH_W,
  parameter int RPT_W    = DEF_RPT_W,
  parameter int TIM_BASE = DEF_TIM_BASE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [2*PH_W-1:0]   bus_wdata,
  output logic [2*PH_W-1:0]   bus_rdata,
  output logic [NUM_CH-1:0]   pwm_out
);
  localparam int DATA_W = 2 * PH_W;

  logic [NUM_CH-1:0] ctl_sel, tim_sel;
  logic              hit;
  logic [DATA_W-1:0] ctl_q [NUM_CH];
  logic [DATA_W-1:0] tim_q [NUM_CH];

  pwm_bus_dec #(
    .NUM_CH  (NUM_CH),
    .ADDR_W  (ADDR_W),
    .TIM_BASE(TIM_BASE)
  ) u_dec (
    .addr   (bus_addr),
    .ctl_sel(ctl_sel),
    .tim_sel(tim_sel),
    .hit    (hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan #(
      .PH_W  (PH_W),
      .RPT_W (RPT_W),
      .DATA_W(DATA_W)
    ) u_chan (
      .clk   (clk),
      .rst   (rst),
      .ctl_we(bus_we && ctl_sel[c]),
      .tim_we(bus_we && tim_sel[c]),
      .wdata (bus_wdata),
      .ctl_q (ctl_q[c]),
      .tim_q (tim_q[c]),
      .pwm_o (pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ctl_sel[c]) bus_rdata = bus_rdata | ctl_q[c];
      if (tim_sel[c]) bus_rdata = bus_rdata | tim_q[c];
    end
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (bus_rdata == '0)); // R8
  AST_ONE_REGISTER_SELECTED: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_sel, tim_sel})); // R1
endmodule

// File: tb/tb_pwm_leadin_array.sv
module tb_pwm_leadin_array;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [5:0]  pwm_out;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk; // 50 MHz

  pwm_leadin_array dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic logic model_out(int k, int lead, int h, int lo, int n);
    int p, per;
    if (k < lead) return 1'b0;
    p   = k - lead;
    per = (h + lo == 0) ? 1 : h + lo;
    if (n != 0 && (p / per) >= n) return 1'b0;
    return (p % per) < h;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctl_word(int en, int lead, int n);
    return {en[0], lead[14:0], n[15:0]};
  endfunction

  // Program one channel, enable it and compare its waveform cycle by cycle
  task automatic run_cfg(int ch, int h, int lo, int lead, int n);
    int per, win, bad_k;
    logic [31:0] rd;
    logic exp_b, act_b;
    logic [5:0] others;
    per   = (h + lo == 0) ? 1 : h + lo;
    win   = lead + 3 * per + 3;
    bad_k = -1;
    exp_b = 1'b0;
    act_b = 1'b0;
    others = '0;
    bus_wr(8'h20 + 8'(4 * ch), {h[15:0], lo[15:0]});
    bus_wr(8'(4 * ch), ctl_word(1, lead, n));
    for (int k = 0; k < win; k++) begin
      if (bad_k < 0 && pwm_out[ch] !== model_out(k, lead, h, lo, n)) begin
        bad_k = k;
        act_b = pwm_out[ch];
        exp_b = model_out(k, lead, h, lo, n);
      end
      others = others | (pwm_out & ~(6'b1 << ch));
      @(negedge clk);
    end
    // R3 R4 R5 waveform of the channel under test
    chk("R3/R4/R5", $sformatf("wave ch=%0d h=%0d lo=%0d lead=%0d n=%0d k=%0d",
        ch, h, lo, lead, n, bad_k), {31'b0, act_b}, {31'b0, exp_b});
    chk("R1", $sformatf("other outputs idle ch=%0d", ch), {26'b0, others}, 32'b0);
    if (n != 0) begin
      bus_rd(8'(4 * ch), rd);
      chk("R5", $sformatf("self-cleared enable ch=%0d", ch), rd, ctl_word(0, lead, n));
    end
    bus_wr(8'(4 * ch), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst       = 1'b1;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    chk("R9", "outputs after reset", {26'b0, pwm_out}, 32'b0);
    for (int a = 0; a < 64; a += 4) begin
      bus_rd(8'(a), rd);
      chk("R9", $sformatf("register 0x%0h after reset", a), rd, 32'b0);
    end
    @(negedge clk);

    // R1 R2 register map and readback
    for (int c = 0; c < 6; c++) begin
      bus_wr(8'h20 + 8'(4 * c), {16'h1000 + 16'(c), 16'h2000 + 16'(c)});
      bus_wr(8'(4 * c), {1'b0, 15'h1234 + 15'(c), 16'hBEE0 + 16'(c)});
    end
    for (int c = 0; c < 6; c++) begin
      bus_rd(8'h20 + 8'(4 * c), rd);
      chk("R1", $sformatf("timing readback ch=%0d", c), rd,
          {16'h1000 + 16'(c), 16'h2000 + 16'(c)});
      bus_rd(8'(4 * c), rd);
      chk("R2", $sformatf("control readback ch=%0d", c), rd,
          {1'b0, 15'h1234 + 15'(c), 16'hBEE0 + 16'(c)});
    end
    @(negedge clk);
    chk("R2", "outputs stay low with enable clear", {26'b0, pwm_out}, 32'b0);
    for (int c = 0; c < 6; c++) bus_wr(8'(4 * c), 32'h0);

    // R8 unmapped addresses
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_wr(8'h3C, 32'hFFFF_FFFF);
    bus_wr(8'h40, 32'hFFFF_FFFF);
    bus_wr(8'h01, 32'hFFFF_FFFF);
    bus_wr(8'h22, 32'hFFFF_FFFF);
    repeat (4) @(negedge clk);
    chk("R8", "outputs after unmapped writes", {26'b0, pwm_out}, 32'b0);
    bus_rd(8'h18, rd); chk("R8", "read 0x18", rd, 32'b0);
    bus_rd(8'h1C, rd); chk("R8", "read 0x1C", rd, 32'b0);
    bus_rd(8'h38, rd); chk("R8", "read 0x38", rd, 32'b0);
    bus_rd(8'h40, rd); chk("R8", "read 0x40", rd, 32'b0);
    bus_rd(8'hFD, rd); chk("R8", "read 0xFD", rd, 32'b0);
    bus_rd(8'h00, rd); chk("R8", "ch0 control untouched", rd, 32'b0);
    bus_rd(8'h20, rd); chk("R8", "ch0 timing untouched", rd, {16'h1000, 16'h2000});
    @(negedge clk);

    // R3 R4 R5 sweep
    begin
      int idx;
      idx = 0;
      for (int h = 0; h < 4; h++)
        for (int lo = 0; lo < 4; lo++)
          for (int li = 0; li < 2; li++)
            for (int ni = 0; ni < 2; ni++) begin
              run_cfg(idx % 6, h, lo, li * 2, ni * 2);
              idx++;
            end
    end

    // R6 disable mid-period, then restart with lead-in
    begin
      int bad;
      bad = 0;
      bus_wr(8'h24, {16'd5, 16'd5});
      bus_wr(8'h04, ctl_word(1, 0, 0));
      chk("R6", "high before disable k=0", {31'b0, pwm_out[1]}, 32'd1);
      @(negedge clk);
      bus_wr(8'h04, ctl_word(0, 0, 0));
      for (int k = 0; k < 12; k++) begin
        if (pwm_out[1] !== 1'b0) bad++;
        @(negedge clk);
      end
      chk("R6", "low cycles after disable with errors", bad, 0);
      bad = 0;
      bus_wr(8'h04, ctl_word(1, 3, 0));
      for (int k = 0; k < 16; k++) begin
        if (pwm_out[1] !== model_out(k, 3, 5, 5, 0)) bad++;
        @(negedge clk);
      end
      chk("R6", "restart from lead-in mismatches", bad, 0);
      bus_wr(8'h04, 32'h0);
    end

    // R7 timing rewrite during a period
    begin
      int bad;
      logic e;
      bad = 0;
      bus_wr(8'h2C, {16'd4, 16'd4});
      bus_wr(8'h0C, ctl_word(1, 0, 0));
      for (int k = 0; k < 20; k++) begin
        e = (k < 8) ? (k < 4) : (((k - 8) % 3) < 2);
        if (pwm_out[3] !== e) bad++;
        if (k == 2) bus_wr(8'h2C, {16'd2, 16'd1});
        else @(negedge clk);
      end
      chk("R7", "old period kept, new values next period, mismatches", bad, 0);
      bus_wr(8'h0C, 32'h0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule